// File: doc/BRIEF.md
# DRAM Row/Column Address Sequencer

This block turns a single request for a 14-bit display-memory address into one dynamic RAM access. The low twelve address bits go out over a 6-bit multiplexed bus: the row half first and the column half second. An active-low row strobe and an active-low column strobe frame each half. The two top address bits do not reach the RAM bus. They select one of four page-pair enables, and that enable is driven only while the access is under way.

A one-clock request pulse in the idle state starts an access. The block captures the address on that clock and holds it for the whole access. The access then runs through a fixed sequence of states: `ST_IDLE` → `ST_RAS` (row strobe low, row half on the bus) → `ST_HOLD` (one further clock of row hold) → `ST_COL` (bus switched to the column half) → `ST_CAS` (column strobe low for `CAS_CYC` clocks) → `ST_PRE` (both strobes high) → `ST_IDLE`. The state moves from `ST_IDLE` to `ST_RAS` only on a request, and from `ST_CAS` to `ST_PRE` only when the column-strobe counter reaches zero. Every other transition is unconditional. A request seen in any state other than `ST_IDLE` is dropped.

Top module: `dram_addr_mux`

## Requirements
- R1: After reset `ras_n` and `cas_n` are 1, `page_en` is 0000 and `ma` is 000000.
- R2: A request sampled high in idle captures `addr`. In the next cycle `ras_n` is 0, `cas_n` is 1 and `ma` equals `addr[5:0]`.
- R3: In the second cycle of an access `ras_n` stays 0, `cas_n` stays 1 and `ma` still carries `addr[5:0]`.
- R4: In the third cycle `ma` switches to `addr[11:6]` while `ras_n` is 0 and `cas_n` is 1.
- R5: In the next `CAS_CYC` cycles `cas_n` is 0, `ras_n` is 0 and `ma` holds `addr[11:6]`. `cas_n` is never 0 while `ras_n` is 1.
- R6: After the column phase there is one cycle with both strobes at 1, and then the block is idle. One access occupies `CAS_CYC+4` cycles. In idle, `ma` shows bits [5:0] of the last captured address.
- R7: `page_en` is one-hot, with bit index `addr[13:12]`. Bit 0 enables pages 1/2, bit 1 pages 3/4, bit 2 pages 5/6 and bit 3 pages 7/8.
- R8: `page_en` is 0000 in idle and in the cycle where both strobes are released. It is non-zero only while `ras_n` is 0.
- R9: Changes on `addr` after the request clock have no effect on `ma` or `page_en` for the rest of that access.
- R10: A request that arrives while an access is in progress, including in its final cycle, is ignored. No further row strobe follows unless a new request arrives in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled only in idle |
| addr | input | 14 | Display-memory address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ma | output | 6 | Multiplexed RAM address |
| page_en | output | 4 | One-hot page-pair enable |

## Verification
The bench builds the block with `CAS_CYC` = 3 instead of the default 2. A column phase of several clocks makes the counter's load, its decrement and its zero exit all visible at the ports. It also makes the run-length check on `cas_n` meaningful. The address width and bus width stay at their defaults, so all four page codes and both address halves are driven with distinct patterns.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAS,
        ST_HOLD,
        ST_COL,
        ST_CAS,
        ST_PRE
    } seq_state_t;
endpackage

// File: rtl/addr_hold.sv
module addr_hold #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (capture) begin
            addr_q <= addr;
        end
    end
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
    import dram_mux_pkg::*;
#(
    parameter int CAS_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic capture,
    output logic row_sel,
    output logic active,
    output logic ras_n,
    output logic cas_n
);
    localparam int CNT_W = (CAS_CYC > 1) ? $clog2(CAS_CYC) : 1;

    seq_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;

    // state register and column-strobe counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_COL) begin
                cnt <= CNT_W'(CAS_CYC - 1);
            end else if (state == ST_CAS && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req) state_nx = ST_RAS;
            ST_RAS:  state_nx = ST_HOLD;
            ST_HOLD: state_nx = ST_COL;
            ST_COL:  state_nx = ST_CAS;
            ST_CAS:  if (cnt == '0) state_nx = ST_PRE;
            ST_PRE:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        capture = 1'b0;
        row_sel = 1'b1;
        active  = 1'b0;
        ras_n   = 1'b1;
        cas_n   = 1'b1;
        unique case (state)
            ST_IDLE: capture = req;
            ST_RAS, ST_HOLD: begin
                active = 1'b1;
                ras_n  = 1'b0;
            end
            ST_COL: begin
                active  = 1'b1;
                ras_n   = 1'b0;
                row_sel = 1'b0;
            end
            ST_CAS: begin
                active  = 1'b1;
                ras_n   = 1'b0;
                cas_n   = 1'b0;
                row_sel = 1'b0;
            end
            ST_PRE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/row_col_mux.sv
module row_col_mux #(
    parameter int ROW_W = 6
) (
    input  logic [2*ROW_W-1:0] low_addr,
    input  logic               row_sel,
    output logic [ROW_W-1:0]   ma
);
    for (genvar b = 0; b < ROW_W; b++) begin : g_bit
        assign ma[b] = row_sel ? low_addr[b] : low_addr[ROW_W + b];
    end
endmodule

// File: rtl/page_decode.sv
module page_decode #(
    parameter int PAGE_BITS = 2
) (
    input  logic [PAGE_BITS-1:0]      sel,
    input  logic                      active,
    output logic [(1<<PAGE_BITS)-1:0] page_en
);
    localparam int PAGES = 1 << PAGE_BITS;
    for (genvar p = 0; p < PAGES; p++) begin : g_page
        assign page_en[p] = active && (sel == PAGE_BITS'(p));
    end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
    parameter int ADDR_W  = 14,
    parameter int ROW_W   = 6,
    parameter int CAS_CYC = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    req,
    input  logic [ADDR_W-1:0]                       addr,
    output logic                                    ras_n,
    output logic                                    cas_n,
    output logic [ROW_W-1:0]                        ma,
    output logic [(1<<(ADDR_W-2*ROW_W))-1:0]        page_en
);
    localparam int PAGE_BITS = ADDR_W - 2*ROW_W;

    logic              capture, row_sel, active;
    logic [ADDR_W-1:0] addr_q;

    strobe_seq #(.CAS_CYC(CAS_CYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .capture (capture),
        .row_sel (row_sel),
        .active  (active),
        .ras_n   (ras_n),
        .cas_n   (cas_n)
    );

    addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .addr    (addr),
        .addr_q  (addr_q)
    );

    row_col_mux #(.ROW_W(ROW_W)) u_mux (
        .low_addr (addr_q[2*ROW_W-1:0]),
        .row_sel  (row_sel),
        .ma       (ma)
    );

    page_decode #(.PAGE_BITS(PAGE_BITS)) u_page (
        .sel     (addr_q[ADDR_W-1:2*ROW_W]),
        .active  (active),
        .page_en (page_en)
    );
endmodule

// File: rtl/dram_addr_mux_chk.sv
module dram_addr_mux_chk #(
    parameter int ROW_W   = 6,
    parameter int PAGES   = 4,
    parameter int CAS_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic [ROW_W-1:0] ma,
    input  logic [PAGES-1:0] page_en
);
    logic [15:0] cas_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cas_run <= '0;
        else        cas_run <= cas_n ? 16'd0 : cas_run + 16'd1;
    end

    assert_start_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(req));

    assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |=> (!ras_n && cas_n && $stable(ma)));

    assert_col_before_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ($stable(ma) && !$past(ras_n)));

    assert_cas_inside_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    assert_cas_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> (cas_run == 16'(CAS_CYC)));

    assert_release_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> $rose(ras_n));

    assert_page_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(page_en));

    assert_page_only_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (page_en != '0) |-> !ras_n);
endmodule

bind dram_addr_mux dram_addr_mux_chk #(
    .ROW_W   (ROW_W),
    .PAGES   (1 << (ADDR_W - 2*ROW_W)),
    .CAS_CYC (CAS_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .ma      (ma),
    .page_en (page_en)
);

// File: tb/dram_addr_mux_tb_top.sv
module dram_addr_mux_tb_top;
    localparam int CC  = 3;
    localparam int ACC = CC + 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [13:0] addr = '0;
    logic        ras_n, cas_n;
    logic [5:0]  ma;
    logic [3:0]  page_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dram_addr_mux #(.ADDR_W(14), .ROW_W(6), .CAS_CYC(CC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr),
        .ras_n(ras_n), .cas_n(cas_n), .ma(ma), .page_en(page_en)
    );

    task automatic chk(string tag, logic [11:0] got, logic [11:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%03h exp=%03h (ras,cas,page,ma)", tag, got, exp);
        end
    endtask

    function automatic logic [11:0] exp_at(int i, logic [13:0] a);
        logic [3:0] pg;
        pg = 4'b0001 << a[13:12];
        if (i <= 2)           return {1'b0, 1'b1, pg, a[5:0]};
        else if (i == 3)      return {1'b0, 1'b1, pg, a[11:6]};
        else if (i <= 3 + CC) return {1'b0, 1'b0, pg, a[11:6]};
        else                  return {1'b1, 1'b1, 4'b0000, a[5:0]};
    endfunction

    function automatic string tag_at(int i);
        if (i == 1)       return "R2";
        if (i == 2)       return "R3";
        if (i == 3)       return "R4";
        if (i <= 3 + CC)  return "R5";
        return "R6";
    endfunction

    function automatic logic [11:0] outs();
        return {ras_n, cas_n, page_en, ma};
    endfunction

    // one access; disturb=1 keeps req high and scrambles addr throughout
    task automatic run_access(logic [13:0] a, bit disturb);
        @(negedge clk);
        addr = a;
        req  = 1'b1;
        @(negedge clk);
        for (int i = 1; i <= ACC; i++) begin
            chk(disturb && i > 1 ? "R9" : tag_at(i), outs(), exp_at(i, a));
            if (i == 1) chk("R7", {8'h0, page_en}, {8'h0, 4'b0001 << a[13:12]});
            if (i == ACC) chk("R8", {8'h0, page_en}, 12'h0);
            req  = disturb;
            addr = disturb ? ~a : a;
            @(negedge clk);
        end
        req = 1'b0;
        chk(disturb ? "R10" : "R6", outs(), exp_at(ACC + 1, a));
        chk("R8", {8'h0, page_en}, 12'h0);
        @(negedge clk);
        chk(disturb ? "R10" : "R6", outs(), exp_at(ACC + 1, a));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", outs(), {1'b1, 1'b1, 4'b0, 6'b0});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", outs(), {1'b1, 1'b1, 4'b0, 6'b0});
    endtask

    task automatic t_all_pages();
        run_access(14'b00_101010_010101, 1'b0);
        run_access(14'b01_111000_000111, 1'b0);
        run_access(14'b10_000001_100000, 1'b0);
        run_access(14'b11_110011_001100, 1'b0);
    endtask

    task automatic t_disturb();
        run_access(14'b10_011011_100100, 1'b1);
        run_access(14'b01_000000_111111, 1'b1);
    endtask

    task automatic t_idle_no_start();
        repeat (5) begin
            @(negedge clk);
            chk("R10", {10'h0, ras_n, cas_n}, 12'h003);
        end
    endtask

    initial begin
        t_reset();
        t_all_pages();
        t_disturb();
        t_idle_no_start();
        run_access(14'h3FFF, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule